// File: doc/BRIEF.md
# Multi-Page-Size Address Translation Buffer

This block is a fully associative, software-loaded translation buffer. It holds 32 register-based entries. Each entry maps a virtual page to a physical frame and carries its own page size, so 1 KB, 4 KB, 8 KB and 1 MB pages can be valid at the same time. Every lookup compares the request against all entries at once. Each comparison is masked by that entry's page size. The physical address, the hit flag and a fault code come out combinationally in the same cycle as the request, so a hit costs no extra cycle.

Software fills the buffer through a load port. A load writes one whole entry at a chosen index: virtual tag, physical frame, size code, permission bits and valid bit. An invalidate-all input empties the buffer in one cycle. There is no hardware table walker. A miss is reported with a fault code and left to software. A request with translation turned off passes its address through unchanged. A system with separate instruction and data buffers uses two instances of this block.

Top module: `xlat_tlb`

## Requirements
- R1: The buffer holds 32 entries. An entry written at any index can translate any address, and every valid entry is compared with each request.
- R2: The size code selects the number of offset bits: 2'b00 gives 10 (1 KB), 2'b01 gives 12 (4 KB), 2'b10 gives 13 (8 KB) and 2'b11 gives 20 (1 MB). An entry matches when the virtual address bits above its offset equal the same bits of {vtag, 10'b0}. Entries of different sizes may be valid together.
- R3: On a hit, `rsp_pa` takes the bits above the matched entry's offset from {frame, 10'b0}, and the offset bits from `req_va`.
- R4: Lookups are combinational. The outputs depend on the current request and on the entries stored at earlier clock edges. A load becomes visible starting with the cycle after the edge that writes it.
- R5: With translation on, a request that matches no valid entry gives `rsp_fault` = 2'b01 (miss), `rsp_hit` = 0, `rsp_pa` = 0 and `rsp_multi` = 0.
- R6: The permission bits are [0] read allowed, [1] write allowed, [2] execute allowed and [3] user access allowed. The access code `req_acc` is 2'b00 for read, 2'b01 for write, 2'b10 for execute, and 2'b11, which is never granted. A supervisor request (`req_super`=1) does not need bit [3]. A hit that fails these checks gives `rsp_fault` = 2'b10, keeps `rsp_hit` = 1 and still drives the translated address. A hit that passes them gives `rsp_fault` = 2'b00. The code 2'b11 never appears on `rsp_fault`.
- R7: When several valid entries match, the lowest-numbered one provides the translation and the permissions, and `rsp_multi` is 1. Otherwise `rsp_multi` is 0.
- R8: With `xlat_en` = 0, `rsp_pa` equals `req_va`, `rsp_hit` = 0, `rsp_fault` = 2'b00 and `rsp_multi` = 0, whatever the stored entries hold.
- R9: A load with `ld_valid` = 0 invalidates only the entry at `ld_idx`. Other entries keep translating.
- R10: `flush_all` clears every valid bit at one clock edge. If a load arrives in the same cycle, the flush takes priority.
- R11: After reset, every entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_all | input | 1 | Invalidate every entry at this edge |
| ld_en | input | 1 | Write an entry at this edge |
| ld_idx | input | 5 | Index of the entry written |
| ld_vtag | input | 22 | Virtual tag, virtual address bits 31:10 |
| ld_frame | input | 22 | Physical frame, physical address bits 31:10 |
| ld_size | input | 2 | Page-size code |
| ld_perm | input | 4 | Permission bits {user, exec, write, read} |
| ld_valid | input | 1 | Valid bit of the written entry |
| xlat_en | input | 1 | 1 = translate and check, 0 = pass through |
| req_va | input | 32 | Request virtual address |
| req_acc | input | 2 | Access type code |
| req_super | input | 1 | 1 = supervisor request, 0 = user request |
| rsp_pa | output | 32 | Physical address |
| rsp_hit | output | 1 | A valid entry matched |
| rsp_fault | output | 2 | 00 none, 01 miss, 10 permission violation |
| rsp_multi | output | 1 | More than one entry matched |

## Verification
The bench loads all 32 entries, rotating through the four page sizes. For each entry it probes addresses inside the page and just past its boundary. A design that masks the tag or merges the offset with the wrong width returns frame bits in the offset, or hits on neighbouring pages. It sweeps all 16 permission patterns against every access code in both privilege modes. This exposes a supervisor who is wrongly refused, or a user who is wrongly allowed. It places a 1 MB page over a 4 KB page to test lowest-index priority and single-entry invalidation. It probes a new mapping in the cycle it is written to catch a design that lets the load bypass into the lookup. A flush that lands with a load shows whether a design lets the write win over the clear.

// File: rtl/tlb_pkg.sv
// Shared widths, entry layout, fault codes and page-size masking for the
// translation buffer. Assumes 32-bit addresses and a 1 KB smallest page.
package tlb_pkg;
    localparam int VA_W     = 32;
    localparam int BASE_OFF = 10;
    localparam int TAG_W    = VA_W - BASE_OFF;
    localparam int PERM_W   = 4;

    typedef enum logic [1:0] {
        FLT_NONE = 2'b00,
        FLT_MISS = 2'b01,
        FLT_PERM = 2'b10
    } fault_e;

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  vtag;
        logic [TAG_W-1:0]  frame;
        logic [1:0]        size;
        logic [PERM_W-1:0] perm;
    } tlb_ent_t;

    // Number of offset bits for a page-size code.
    function automatic int off_bits(input logic [1:0] sz);
        case (sz)
            2'b00:   return 10;
            2'b01:   return 12;
            2'b10:   return 13;
            default: return 20;
        endcase
    endfunction

    // Tag-field mask: ones on the tag bits that take part in matching.
    function automatic logic [TAG_W-1:0] size_mask(input logic [1:0] sz);
        return ~((TAG_W'(1) << (off_bits(sz) - BASE_OFF)) - TAG_W'(1));
    endfunction

    // Access rule: supervisor skips the user bit; access code 3 is never granted.
    function automatic logic access_ok(input logic [PERM_W-1:0] perm,
                                       input logic [1:0] acc,
                                       input logic sup);
        logic type_ok;
        case (acc)
            2'b00:   type_ok = perm[0];
            2'b01:   type_ok = perm[1];
            2'b10:   type_ok = perm[2];
            default: type_ok = 1'b0;
        endcase
        return type_ok && (sup || perm[3]);
    endfunction
endpackage

// File: rtl/tlb_store.sv
// Entry register file. Holds ENTRIES entries and writes one per cycle from the
// load port. Assumes flush_all has priority over a load in the same cycle.
module tlb_store
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush_all,
    input  logic                      ld_en,
    input  logic [IDX_W-1:0]          ld_idx,
    input  tlb_ent_t                  ld_ent,
    output tlb_ent_t [ENTRIES-1:0]    ents
);
    // Reset, flush or single-entry write of the stored entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ents <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (flush_all)
                    ents[i].valid <= 1'b0;
                else if (ld_en && ld_idx == IDX_W'(i))
                    ents[i] <= ld_ent;
            end
        end
    end
endmodule

// File: rtl/tlb_cam.sv
// Parallel tag compare. Every entry checks the request tag under its own
// page-size mask and produces one match bit. Purely combinational.
module tlb_cam
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 32
) (
    input  tlb_ent_t [ENTRIES-1:0] ents,
    input  logic [TAG_W-1:0]       va_tag,
    output logic [ENTRIES-1:0]     match_vec
);
    // Masked compare of each entry against the request tag.
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            match_vec[i] = ents[i].valid &&
                (((ents[i].vtag ^ va_tag) & size_mask(ents[i].size)) == '0);
        end
    end
endmodule

// File: rtl/tlb_resolve.sv
// Picks the lowest matching entry, merges frame and offset under that entry's
// mask, checks permissions and forms the fault code. Purely combinational.
module tlb_resolve
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  tlb_ent_t [ENTRIES-1:0] ents,
    input  logic [ENTRIES-1:0]     match_vec,
    input  logic                   xlat_en,
    input  logic [VA_W-1:0]        req_va,
    input  logic [1:0]             req_acc,
    input  logic                   req_super,
    output logic [VA_W-1:0]        rsp_pa,
    output logic                   rsp_hit,
    output logic [1:0]             rsp_fault,
    output logic                   rsp_multi
);
    logic [IDX_W-1:0] sel;
    tlb_ent_t         win;
    logic [TAG_W-1:0] win_mask;

    // Priority encoder: the lowest index that matched wins.
    always_comb begin
        sel = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) sel = IDX_W'(i);
        end
    end

    assign win      = ents[sel];
    assign win_mask = size_mask(win.size);

    // Output formation for bypass, miss, violation and clean hit.
    always_comb begin
        rsp_pa    = req_va;
        rsp_hit   = 1'b0;
        rsp_fault = FLT_NONE;
        rsp_multi = 1'b0;
        if (xlat_en) begin
            if (match_vec == '0) begin
                rsp_pa    = '0;
                rsp_fault = FLT_MISS;
            end else begin
                rsp_pa    = {(win.frame & win_mask) |
                             (req_va[VA_W-1:BASE_OFF] & ~win_mask),
                             req_va[BASE_OFF-1:0]};
                rsp_hit   = 1'b1;
                rsp_multi = (match_vec & (match_vec - 1'b1)) != '0;
                rsp_fault = access_ok(win.perm, req_acc, req_super) ? FLT_NONE : FLT_PERM;
            end
        end
    end
endmodule

// File: rtl/xlat_tlb.sv
// Top of the fully associative multi-page-size translation buffer. Storage is
// registered; matching and resolution are combinational in the request cycle.
module xlat_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_all,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [TAG_W-1:0]  ld_vtag,
    input  logic [TAG_W-1:0]  ld_frame,
    input  logic [1:0]        ld_size,
    input  logic [PERM_W-1:0] ld_perm,
    input  logic              ld_valid,
    input  logic              xlat_en,
    input  logic [VA_W-1:0]   req_va,
    input  logic [1:0]        req_acc,
    input  logic              req_super,
    output logic [VA_W-1:0]   rsp_pa,
    output logic              rsp_hit,
    output logic [1:0]        rsp_fault,
    output logic              rsp_multi
);
    tlb_ent_t               ld_ent;
    tlb_ent_t [ENTRIES-1:0] ents;
    logic [ENTRIES-1:0]     match_vec;

    // Pack load fields into one entry.
    always_comb begin
        ld_ent.valid = ld_valid;
        ld_ent.vtag  = ld_vtag;
        ld_ent.frame = ld_frame;
        ld_ent.size  = ld_size;
        ld_ent.perm  = ld_perm;
    end

    tlb_store #(.ENTRIES(ENTRIES)) i_store (
        .clk(clk), .rst_n(rst_n), .flush_all(flush_all), .ld_en(ld_en),
        .ld_idx(ld_idx), .ld_ent(ld_ent), .ents(ents)
    );

    tlb_cam #(.ENTRIES(ENTRIES)) i_cam (
        .ents(ents), .va_tag(req_va[VA_W-1:BASE_OFF]), .match_vec(match_vec)
    );

    tlb_resolve #(.ENTRIES(ENTRIES)) i_resolve (
        .ents(ents), .match_vec(match_vec), .xlat_en(xlat_en), .req_va(req_va),
        .req_acc(req_acc), .req_super(req_super), .rsp_pa(rsp_pa),
        .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_multi(rsp_multi)
    );
endmodule

// File: rtl/tlb_chk.sv
// Port-level properties of the translation buffer, bound into every instance.
module tlb_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        flush_all,
    input logic        xlat_en,
    input logic [31:0] req_va,
    input logic [31:0] rsp_pa,
    input logic        rsp_hit,
    input logic [1:0]  rsp_fault,
    input logic        rsp_multi
);
    // R8
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xlat_en |-> (rsp_pa == req_va && !rsp_hit && rsp_fault == 2'b00 && !rsp_multi));

    // R5
    miss_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault == 2'b01 |-> (!rsp_hit && rsp_pa == 32'h0 && !rsp_multi));

    // R3
    offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_pa[9:0] == req_va[9:0]);

    // R7
    multi_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_multi |-> rsp_hit);

    // R6
    fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault != 2'b11);

    // R10
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flush_all) && xlat_en) |-> rsp_fault == 2'b01);
endmodule

bind xlat_tlb tlb_chk i_chk (.*);

// File: tb/test_xlat_tlb.sv
module test_xlat_tlb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_all = 1'b0;
    logic        ld_en = 1'b0;
    logic [4:0]  ld_idx = '0;
    logic [21:0] ld_vtag = '0;
    logic [21:0] ld_frame = '0;
    logic [1:0]  ld_size = '0;
    logic [3:0]  ld_perm = '0;
    logic        ld_valid = 1'b0;
    logic        xlat_en = 1'b0;
    logic [31:0] req_va = '0;
    logic [1:0]  req_acc = '0;
    logic        req_super = 1'b0;
    logic [31:0] rsp_pa;
    logic        rsp_hit;
    logic [1:0]  rsp_fault;
    logic        rsp_multi;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench-side image of the buffer
    bit          m_v  [32];
    logic [21:0] m_tag[32];
    logic [21:0] m_fr [32];
    logic [1:0]  m_sz [32];
    logic [3:0]  m_pm [32];

    logic [21:0] tags[32];

    always #2 clk = ~clk;

    xlat_tlb i_xlat_tlb (.*);

    function automatic int nbits(input logic [1:0] s);
        return (s == 2'd0) ? 10 : (s == 2'd1) ? 12 : (s == 2'd2) ? 13 : 20;
    endfunction

    task automatic expect_now(input string req);
        logic [31:0] pa; logic hit; logic [1:0] flt; logic mul;
        int cnt; int first; logic [31:0] msk; logic ok; logic tbit;
        cnt = 0; first = -1;
        if (!xlat_en) begin
            pa = req_va; hit = 0; flt = 2'b00; mul = 0;
        end else begin
            for (int i = 0; i < 32; i++) begin
                if (m_v[i] && ((req_va >> nbits(m_sz[i])) ==
                               ({m_tag[i], 10'b0} >> nbits(m_sz[i])))) begin
                    cnt++;
                    if (first < 0) first = i;
                end
            end
            if (cnt == 0) begin
                pa = 0; hit = 0; flt = 2'b01; mul = 0;
            end else begin
                msk = (32'h1 << nbits(m_sz[first])) - 1;
                pa  = ({m_fr[first], 10'b0} & ~msk) | (req_va & msk);
                hit = 1; mul = (cnt > 1);
                tbit = (req_acc == 2'd3) ? 1'b0 : m_pm[first][req_acc];
                ok  = tbit && (req_super || m_pm[first][3]);
                flt = ok ? 2'b00 : 2'b10;
            end
        end
        checks++;
        if (rsp_pa !== pa || rsp_hit !== hit || rsp_fault !== flt || rsp_multi !== mul) begin
            errors++;
            $display("FAIL %s va=%h: got pa=%h hit=%b flt=%b multi=%b, want pa=%h hit=%b flt=%b multi=%b",
                     req, req_va, rsp_pa, rsp_hit, rsp_fault, rsp_multi, pa, hit, flt, mul);
        end
    endtask

    task automatic look(input logic [31:0] va, input logic [1:0] acc,
                        input logic sup, input logic en, input string req);
        @(negedge clk);
        req_va = va; req_acc = acc; req_super = sup; xlat_en = en;
        #1;
        expect_now(req);
    endtask

    task automatic load(input int idx, input logic [21:0] tag, input logic [21:0] fr,
                        input logic [1:0] sz, input logic [3:0] pm, input logic v);
        @(negedge clk);
        ld_en = 1; ld_idx = 5'(idx); ld_vtag = tag; ld_frame = fr;
        ld_size = sz; ld_perm = pm; ld_valid = v;
        @(posedge clk);
        if (flush_all) begin
            for (int i = 0; i < 32; i++) m_v[i] = 0;
        end else begin
            m_v[idx] = v; m_tag[idx] = tag; m_fr[idx] = fr; m_sz[idx] = sz; m_pm[idx] = pm;
        end
        #1 ld_en = 0;
    endtask

    task automatic in_page(input int i, output logic [31:0] va);
        logic [31:0] msk;
        msk = (32'h1 << nbits(m_sz[i])) - 1;
        va = ({m_tag[i], 10'b0} & ~msk) | ($urandom & msk);
    endtask

    initial begin
        logic [31:0] va;
        for (int i = 0; i < 32; i++) m_v[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R11: empty after reset
        look(32'h1234_5678, 2'd0, 1, 1, "R11");
        look(32'h0000_0000, 2'd1, 0, 1, "R11");

        // R8: pass-through
        for (int k = 0; k < 8; k++) look($urandom, 2'(k), k[0], 0, "R8");

        // R1 R2 R3: fill every index with rotating sizes
        for (int i = 0; i < 32; i++) begin
            tags[i] = {5'(i), 17'($urandom)};
            load(i, tags[i], 22'($urandom), 2'(i % 4), 4'hF, 1);
        end
        for (int i = 0; i < 32; i++) begin
            for (int r = 0; r < 3; r++) begin
                in_page(i, va);
                look(va, 2'(r), r[0], 1, "R3");
            end
            in_page(i, va);
            look(va ^ (32'h1 << nbits(m_sz[i])), 2'd0, 1, 1, "R2");
        end
        // R8 with full buffer
        in_page(4, va);
        look(va, 2'd0, 1, 0, "R8");

        // R6: full permission sweep on entry 0
        for (int p = 0; p < 16; p++) begin
            load(0, tags[0], 22'h15A5A, 2'b01, 4'(p), 1);
            in_page(0, va);
            for (int a = 0; a < 4; a++)
                for (int s = 0; s < 2; s++)
                    look(va, 2'(a), s[0], 1, "R6");
        end

        // R10: flush with concurrent load; flush wins
        @(negedge clk) flush_all = 1;
        load(7, tags[7], 22'h00777, 2'b00, 4'hF, 1);
        @(negedge clk) flush_all = 0;
        for (int i = 0; i < 32; i += 5) begin
            in_page(i, va);
            look(va, 2'd0, 1, 1, "R10");
        end
        look({tags[7], 10'h055}, 2'd0, 1, 1, "R10");

        // R4: a load is not visible in its own cycle
        @(negedge clk);
        ld_en = 1; ld_idx = 5'd3; ld_vtag = 22'h2C001; ld_frame = 22'h01234;
        ld_size = 2'b01; ld_perm = 4'hF; ld_valid = 1;
        req_va = {22'h2C001, 10'h1AB}; req_acc = 0; req_super = 1; xlat_en = 1;
        #1 expect_now("R4");
        @(posedge clk);
        m_v[3] = 1; m_tag[3] = 22'h2C001; m_fr[3] = 22'h01234; m_sz[3] = 2'b01; m_pm[3] = 4'hF;
        #1 ld_en = 0;
        look({22'h2C001, 10'h1AB}, 2'd0, 1, 1, "R4");

        // R7: 1 MB page at index 5 over 4 KB page at index 9
        load(9, 22'h10C04, 22'h3F000, 2'b01, 4'b0001, 1);
        load(5, 22'h10C00, 22'h24C00, 2'b11, 4'b1111, 1);
        look({22'h10C04, 10'h3C5}, 2'd1, 0, 1, "R7");
        look({22'h10C07, 10'h011}, 2'd2, 0, 1, "R7");
        // R9: drop index 5 only
        load(5, 22'h10C00, 22'h24C00, 2'b11, 4'b1111, 0);
        look({22'h10C04, 10'h3C5}, 2'd1, 0, 1, "R9");
        look({22'h10C04, 10'h3C5}, 2'd0, 0, 1, "R9");
        look({22'h10C07, 10'h011}, 2'd0, 1, 1, "R9");
        look({22'h2C001, 10'h1AB}, 2'd0, 1, 1, "R9");

        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: got timeout, want completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule